// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter whose pace is set by a programmable prescaler. Every clock in which counting is allowed advances a prescale counter. When that counter reaches the programmed limit, it wraps to zero and the main count advances by one. Four compare channels watch the count. When the count reaches a channel's compare value, that channel can latch an interrupt flag, restart the count, freeze counting, and drive one output pin low, high or to its opposite level.

Software reaches all state through a flat register port: write enable, 4-bit address, write data, and read data that follows the address with no wait cycle. The map is:

| Address | Register |
|---|---|
| 0 | control |
| 1 | prescale limit |
| 2 | prescale count |
| 3 | main count |
| 4 | channel action bits |
| 5 | flags |
| 6 | pin register |
| 7 | source select |
| 8 to 11 | compare values 0 to 3 |

A source-select register can switch the count away from the clock and onto rising edges of one of the count pins. In that case each edge stands in for one clock at the prescaler.

Top module: `prescaled_match_timer`

## Requirements
- R1: In clock mode, with enable set and hold clear, the prescale count steps 0, 1, … up to the prescale limit L and then returns to 0. The main count increments on that wrap, so the main count advances once every L+1 clocks.
- R2: The control register holds enable at bit 0 and hold at bit 1. With enable clear, both counts keep their values. With hold set, both counts are zero one clock later and remain zero, whatever enable is.
- R3: When the main count first becomes equal to compare value i and channel i has its interrupt bit set, flag i is set one clock later. The irq output is high whenever any flag is set. A channel whose interrupt bit is clear never sets its flag.
- R4: The action register gives channel i three bits: interrupt at bit 3i, restart at bit 3i+1 and freeze at bit 3i+2. With restart set, the prescale tick that would move the count past the compare value loads 0 instead.
- R5: With freeze set on channel i, a first equality halts both counts from the next clock on and clears the enable bit.
- R6: Writing the flag register (address 5) clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R7: The pin register holds the pin levels in bits 3:0 and a 2-bit code for channel i in bits 5+2i:4+2i. On a first equality, the code acts on pin i: 00 keeps it, 01 drives it low, 10 drives it high, 11 inverts it. The pin levels can be written, and they read back and appear on match_pins.
- R8: When source-select bit 0 is 1, the pin chosen by bits 2:1 is synchronised through two flip-flops, and each of its rising edges stands for one clock at the prescaler. Edges on the other count pins have no effect on the count.
- R9: Writes to the prescale count (address 2) and to the main count (address 3) load them directly. The main count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Read data for reg_addr, combinational |
| count_pins | input | NUM_IN | External count sources |
| match_pins | output | NUM_CH | Compare-driven output levels |
| irq | output | 1 | High while any flag is set |

## Verification
A wrong prescale count first shows up as a main count that is off by one tick. A read at a chosen clock exposes it within L+1 cycles. A wrong match detector or a stale equality history shows up on the pins, on the flags and on irq one clock after the equality cycle: the event either fires twice, or it does not fire at all. A bad freeze path leaves the enable bit reading 1 one clock after the halt should have happened, or lets the count drift past the compare value. These effects are sampled in the exact cycle the requirements predict.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] RA_PSC_LIM = 4'd1;
  localparam logic [REG_AW-1:0] RA_PSC_CNT = 4'd2;
  localparam logic [REG_AW-1:0] RA_COUNT   = 4'd3;
  localparam logic [REG_AW-1:0] RA_ACTIONS = 4'd4;
  localparam logic [REG_AW-1:0] RA_FLAGS   = 4'd5;
  localparam logic [REG_AW-1:0] RA_PINS    = 4'd6;
  localparam logic [REG_AW-1:0] RA_SOURCE  = 4'd7;
  localparam logic [REG_AW-1:0] RA_CMP0    = 4'd8;

  // per-channel action bit positions inside a 3-bit group
  localparam int unsigned ACT_IRQ  = 0;
  localparam int unsigned ACT_RST  = 1;
  localparam int unsigned ACT_STOP = 2;
  localparam int unsigned ACT_BITS = 3;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_code_e;

  function automatic logic pin_apply(input pin_code_e code, input logic cur);
    case (code)
      PIN_LOW:  return 1'b0;
      PIN_HIGH: return 1'b1;
      PIN_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  // prescale counter reaches or passes its limit
  function automatic logic psc_wrap(input logic [63:0] cnt, input logic [63:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NUM_IN = 4,
  localparam int SW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              hold,
  input  logic              use_pin,
  input  logic [SW-1:0]     pin_sel,
  input  logic [NUM_IN-1:0] pins_in,
  input  logic [CW-1:0]     limit,
  input  logic              pc_load,
  input  logic [CW-1:0]     pc_val,
  output logic [CW-1:0]     pc,
  output logic              tick,
  output logic              pin_rise
);
  logic [2:0] sync_q;
  logic       step;
  logic       at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pins_in[pin_sel]};
  end

  assign pin_rise = sync_q[1] & ~sync_q[2];
  assign step     = use_pin ? pin_rise : 1'b1;
  assign at_lim   = psc_wrap(64'(pc), 64'(limit));
  assign tick     = run_ok & ~hold & ~pc_load & step & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc <= '0;
    else if (hold)           pc <= '0;
    else if (pc_load)        pc <= pc_val;
    else if (run_ok && step) pc <= at_lim ? '0 : pc + CW'(1);
  end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] target,
  input  logic [1:0]    code,
  input  logic          lvl_load,
  input  logic          lvl_val,
  output logic          eq,
  output logic          hit,
  output logic          lvl
);
  logic eq_q;

  assign eq  = (count == target);
  assign hit = eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl <= 1'b0;
    else if (hit)      lvl <= pin_apply(pin_code_e'(code), lvl);
    else if (lvl_load) lvl <= lvl_val;
  end
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import tmr_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NUM_CH = 4,
  parameter int NUM_IN = 4,
  localparam int SW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int AW    = ACT_BITS * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  input  logic [NUM_IN-1:0] count_pins,
  output logic [NUM_CH-1:0] match_pins,
  output logic              irq
);
  logic                run_q, hold_q;
  logic [CW-1:0]       limit_q, tc_q, pc_q;
  logic [AW-1:0]       actions_q;
  logic [NUM_CH-1:0]   flags_q;
  logic [2*NUM_CH-1:0] codes_q;
  logic                use_pin_q;
  logic [SW-1:0]       pin_sel_q;
  logic [CW-1:0]       cmp_q [NUM_CH];

  logic wr_ctrl, wr_limit, wr_pc, wr_count, wr_actions, wr_flags, wr_pins, wr_source;
  logic [NUM_CH-1:0] eq_v, hit_v, irq_en, rst_en, stop_en, flag_set;
  logic rst_hit, stop_evt, run_ok, tick, pin_rise;

  assign wr_ctrl    = reg_we && (reg_addr == RA_CTRL);
  assign wr_limit   = reg_we && (reg_addr == RA_PSC_LIM);
  assign wr_pc      = reg_we && (reg_addr == RA_PSC_CNT);
  assign wr_count   = reg_we && (reg_addr == RA_COUNT);
  assign wr_actions = reg_we && (reg_addr == RA_ACTIONS);
  assign wr_flags   = reg_we && (reg_addr == RA_FLAGS);
  assign wr_pins    = reg_we && (reg_addr == RA_PINS);
  assign wr_source  = reg_we && (reg_addr == RA_SOURCE);

  // per-channel compare, pin and action decode
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [REG_AW-1:0] CADDR = REG_AW'(int'(RA_CMP0) + i);
    logic wr_cmp;
    assign wr_cmp = reg_we && (reg_addr == CADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q[i] <= '0;
      else if (wr_cmp) cmp_q[i] <= reg_wdata;
    end

    assign irq_en[i]  = actions_q[ACT_BITS*i + ACT_IRQ];
    assign rst_en[i]  = actions_q[ACT_BITS*i + ACT_RST];
    assign stop_en[i] = actions_q[ACT_BITS*i + ACT_STOP];

    tmr_match_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (tc_q),
      .target   (cmp_q[i]),
      .code     (codes_q[2*i +: 2]),
      .lvl_load (wr_pins),
      .lvl_val  (reg_wdata[i]),
      .eq       (eq_v[i]),
      .hit      (hit_v[i]),
      .lvl      (match_pins[i])
    );
  end

  assign flag_set = hit_v & irq_en;
  assign rst_hit  = |(eq_v & rst_en);
  assign stop_evt = |(hit_v & stop_en);
  assign run_ok   = run_q & ~hold_q & ~stop_evt;
  assign irq      = |flags_q;

  tmr_tick_gen #(.CW(CW), .NUM_IN(NUM_IN)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_ok   (run_ok),
    .hold     (hold_q),
    .use_pin  (use_pin_q),
    .pin_sel  (pin_sel_q),
    .pins_in  (count_pins),
    .limit    (limit_q),
    .pc_load  (wr_pc),
    .pc_val   (reg_wdata),
    .pc       (pc_q),
    .tick     (tick),
    .pin_rise (pin_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= reg_wdata[0];
        hold_q <= reg_wdata[1];
      end
      if (stop_evt) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tc_q <= '0;
    else if (hold_q)   tc_q <= '0;
    else if (wr_count) tc_q <= reg_wdata;
    else if (tick)     tc_q <= rst_hit ? '0 : tc_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q   <= '0;
      actions_q <= '0;
      codes_q   <= '0;
      use_pin_q <= 1'b0;
      pin_sel_q <= '0;
    end else begin
      if (wr_limit)   limit_q   <= reg_wdata;
      if (wr_actions) actions_q <= reg_wdata[AW-1:0];
      if (wr_pins)    codes_q   <= reg_wdata[NUM_CH +: 2*NUM_CH];
      if (wr_source) begin
        use_pin_q <= reg_wdata[0];
        pin_sel_q <= reg_wdata[1 +: SW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~(wr_flags ? reg_wdata[NUM_CH-1:0] : '0)) | flag_set;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:    reg_rdata[1:0] = {hold_q, run_q};
      RA_PSC_LIM: reg_rdata = limit_q;
      RA_PSC_CNT: reg_rdata = pc_q;
      RA_COUNT:   reg_rdata = tc_q;
      RA_ACTIONS: reg_rdata[AW-1:0] = actions_q;
      RA_FLAGS:   reg_rdata[NUM_CH-1:0] = flags_q;
      RA_PINS:    reg_rdata[3*NUM_CH-1:0] = {codes_q, match_pins};
      RA_SOURCE:  reg_rdata[SW:0] = {pin_sel_q, use_pin_q};
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (reg_addr == REG_AW'(int'(RA_CMP0) + i)) reg_rdata = cmp_q[i];
      end
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW     = 32,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              hold_q,
  input logic              wr_count,
  input logic              wr_pc,
  input logic              tick,
  input logic              rst_hit,
  input logic              stop_evt,
  input logic              use_pin_q,
  input logic              pin_rise,
  input logic [NUM_CH-1:0] flag_set,
  input logic              irq,
  input logic [CW-1:0]     tc_q,
  input logic [CW-1:0]     pc_q
);
  AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) hold_q |=> (tc_q == '0 && pc_q == '0)); // R2
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !run_q |-> !tick); // R2
  AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rst_hit && !hold_q && !wr_count) |=> tc_q == $past(tc_q) + CW'(1)); // R1
  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_hit && !hold_q && !wr_count) |=> tc_q == '0); // R4
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !hold_q && !wr_pc && !wr_count) |=> (!run_q && $stable(pc_q) && $stable(tc_q))); // R5
  AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (flag_set != '0) |=> irq); // R3
  AST_PIN_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (use_pin_q && !pin_rise) |-> !tick); // R8
endmodule

bind prescaled_match_timer tmr_checker #(.CW(CW), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .hold_q    (hold_q),
  .wr_count  (wr_count),
  .wr_pc     (wr_pc),
  .tick      (tick),
  .rst_hit   (rst_hit),
  .stop_evt  (stop_evt),
  .use_pin_q (use_pin_q),
  .pin_rise  (pin_rise),
  .flag_set  (flag_set),
  .irq       (irq),
  .tc_q      (tc_q),
  .pc_q      (pc_q)
);

// File: tb/prescaled_match_timer_test.sv
`timescale 1ns/1ps
module prescaled_match_timer_test;
  localparam logic [3:0] A_CTRL = 0, A_LIM = 1, A_PC = 2, A_TC = 3, A_ACT = 4,
                         A_FLG = 5, A_PIN = 6, A_SRC = 7, A_CMP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  count_pins = '0;
  logic [3:0]  match_pins;
  logic        irq;

  always #2.5 clk = ~clk;

  prescaled_match_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_pins(count_pins),
    .match_pins(match_pins), .irq(irq)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  event ev_s;

  // monitor: pops each expected read and compares against the port
  initial forever begin
    item_t it;
    @(ev_s);
    #0.2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      n_cmp++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    reg_addr = a;
    -> ev_s;
    #0.5;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  task automatic clocks(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic restart();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic pulse_sel();
    @(negedge clk);
    count_pins[2] = 1'b1; count_pins[0] = ~count_pins[0];
    clocks(3);
    count_pins[2] = 1'b0; count_pins[0] = ~count_pins[0];
    clocks(3);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clocks(3);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(A_CTRL, 0, "R2 reset ctrl");
    rd(A_TC, 0, "R1 reset count");
    rd(A_FLG, 0, "R3 reset flags");
    chk({31'b0, irq}, 0, "R3 reset irq");
    chk({28'b0, match_pins}, 0, "R7 reset pins");

    // R1 prescale pacing, limit 3
    wr(A_LIM, 3);
    restart();
    clocks(5);
    rd(A_TC, 1, "R1 count after 5");
    rd(A_PC, 1, "R1 prescale after 5");
    wr(A_CTRL, 0);      // two more edges, last one still counting
    clocks(4);
    rd(A_TC, 1, "R2 frozen count");
    rd(A_PC, 3, "R2 frozen prescale");
    wr(A_CTRL, 3);
    clocks(4);
    rd(A_TC, 0, "R2 hold count");
    rd(A_PC, 0, "R2 hold prescale");

    // R3/R4 interrupt + restart on channel 0 at 5, limit 0
    wr(A_CTRL, 0);
    wr(A_LIM, 0);
    wr(A_CMP + 0, 5);
    wr(A_ACT, 32'h3);
    restart();
    clocks(5);
    rd(A_TC, 5, "R4 reaches compare");
    rd(A_FLG, 0, "R3 flag not yet");
    clocks(1);
    rd(A_TC, 0, "R4 restarted");
    rd(A_FLG, 1, "R3 flag set");
    chk({31'b0, irq}, 1, "R3 irq high");
    clocks(1);
    rd(A_TC, 1, "R4 counts on");
    wr(A_CTRL, 0);
    rd(A_TC, 3, "R2 stopped count");
    wr(A_FLG, 32'h0);
    rd(A_FLG, 1, "R6 zero write keeps flag");
    wr(A_FLG, 32'h1);
    rd(A_FLG, 0, "R6 one write clears");
    chk({31'b0, irq}, 0, "R3 irq low");

    // R5 freeze on channel 1 at 3, limit 1
    wr(A_ACT, 32'h20);
    wr(A_CMP + 1, 3);
    wr(A_LIM, 1);
    restart();
    clocks(6);
    rd(A_TC, 3, "R5 at compare");
    rd(A_CTRL, 1, "R5 enable still set");
    clocks(1);
    rd(A_CTRL, 0, "R5 enable cleared");
    clocks(5);
    rd(A_TC, 3, "R5 count held");
    rd(A_PC, 0, "R5 prescale held");

    // R7 pin codes: ch0 flip, ch1 high, ch2 low, ch3 keep
    wr(A_ACT, 0);
    wr(A_LIM, 0);
    wr(A_CMP + 0, 2);
    wr(A_CMP + 1, 3);
    wr(A_CMP + 2, 4);
    wr(A_CMP + 3, 2);
    wr(A_PIN, 32'h1BC);
    rd(A_PIN, 32'h1BC, "R7 pin readback");
    restart();
    clocks(8);
    chk({28'b0, match_pins}, 32'hB, "R7 pins after matches");
    rd(A_PIN, 32'h1BB, "R7 pin register");
    rd(A_FLG, 0, "R3 no flag without enable");
    wr(A_CTRL, 0);
    wr(A_PIN, 32'h1B5);
    chk({28'b0, match_pins}, 32'h5, "R7 level write");

    // R9 direct loads and wrap, limit 5
    wr(A_LIM, 5);
    wr(A_TC, 32'hFFFF_FFFE);
    wr(A_PC, 4);
    wr(A_CTRL, 1);
    clocks(1);
    rd(A_PC, 5, "R9 loaded prescale");
    rd(A_TC, 32'hFFFF_FFFE, "R9 loaded count");
    clocks(1);
    rd(A_TC, 32'hFFFF_FFFF, "R9 all ones");
    clocks(6);
    rd(A_TC, 0, "R9 wrap to zero");

    // R8 counter mode on pin 2
    wr(A_CTRL, 0);
    wr(A_SRC, 32'h5);
    wr(A_LIM, 0);
    restart();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); count_pins[0] = ~count_pins[0];
      clocks(2);
    end
    clocks(4);
    rd(A_TC, 0, "R8 other pin ignored");
    pulse_sel();
    pulse_sel();
    pulse_sel();
    clocks(5);
    rd(A_TC, 3, "R8 three edges");

    done = 1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule